// File: doc/BRIEF.md
# I2C/SMBus Control Register Pair with Hardware Request Handshake

This block holds the software-visible control state of an I2C/SMBus peripheral in two registers. Software reads and writes them over a simple single-cycle register bus. The first register holds the static configuration fields and three request bits: start, stop and PEC-byte transfer. The second register holds the clock divider and the DMA controls. The protocol engine, the DMA logic and the interrupt logic are not part of the block. They reach it only through single-cycle event pulses and level outputs.

The request bits are owned jointly. Software may set or clear them. The engine clears them when it reports that the requested action is done, and a timeout report sets the stop request. While any request is pending, the second register ignores software writes. This keeps a configuration change from landing in the middle of an action the engine has accepted. Reserved bit positions are not stored and always read as zero.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset every stored field is 0, so both registers read 0x0000. The derived outputs `gcall_en_o` and `stretch_en_o` therefore read 1 (with `eng_master_i`=0), and every other output reads 0.
- R2: Register address 0 holds these fields: bit 0 enable, bit 1 SMBus select, bit 3 SMBus host, bit 4 address-resolution enable, bit 5 PEC enable, bit 6 general-call disable, bit 7 stretch disable, bit 8 start request, bit 9 stop request and bit 10 PEC-transfer request. Bits 2 and 15:11 are reserved and always read 0, so writing 0xFFFF reads back as 0x07FB.
- R3: The start request (address 0, bit 8) is cleared at the next clock edge by an `ev_start_sent_i` pulse. The pulse wins over a software write that sets the bit in the same cycle.
- R4: The stop request (address 0, bit 9) is cleared by an `ev_stop_det_i` pulse and set by an `ev_timeout_i` pulse. A timeout wins over a stop detection and over a software clear in the same cycle.
- R5: The PEC-transfer request (address 0, bit 10) is cleared by an `ev_crc_sent_i` pulse, which wins over a software write in the same cycle.
- R6: Register address 1 holds bits 5:0 clock divider, bit 11 DMA enable and bit 12 DMA last-transfer. All other bits read 0, so writing 0xFFFF reads back as 0x183F.
- R7: A software write to address 1 while any of the three request bits is 1 has no effect. Once all requests are 0, writes are accepted again.
- R8: An `ev_xfer_end_i` pulse while the stored enable bit (address 0, bit 0) is 0 clears all three request bits, except that a timeout in the same cycle still sets the stop request. While enable is 1, the pulse changes nothing.
- R9: `release_lines_o` is 1 exactly when the stop request is 1 and `eng_master_i` is 0 (slave mode).
- R10: `stretch_en_o` is 1 exactly when the stretch-disable bit is 0 and `eng_master_i` is 0. `gcall_en_o` is the inverse of the general-call disable bit.
- R11: Reads of addresses 2 and 3 return 0x0000. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| ev_start_sent_i | input | 1 | Engine pulse: start condition sent |
| ev_stop_det_i | input | 1 | Engine pulse: stop condition detected |
| ev_timeout_i | input | 1 | Engine pulse: timeout error |
| ev_crc_sent_i | input | 1 | Engine pulse: PEC byte transferred |
| ev_xfer_end_i | input | 1 | Engine pulse: end of communication |
| eng_master_i | input | 1 | Engine is in master mode |
| start_req_o | output | 1 | Start request level |
| stop_req_o | output | 1 | Stop request level |
| crc_req_o | output | 1 | PEC-transfer request level |
| release_lines_o | output | 1 | Slave must let SCL and SDA go |
| enable_o | output | 1 | Peripheral enable |
| smbus_sel_o | output | 1 | 1 selects SMBus, 0 plain I2C |
| smb_host_o | output | 1 | SMBus host role |
| arp_en_o | output | 1 | Address-resolution response enable |
| crc_en_o | output | 1 | PEC calculation enable |
| gcall_en_o | output | 1 | General-call address response enable |
| stretch_en_o | output | 1 | Slave clock stretching enabled |
| clk_div_o | output | 6 | Clock divider field |
| dma_en_o | output | 1 | DMA enable |
| dma_last_o | output | 1 | Next DMA transfer is the last |

## Verification
The bench drives a hardware event and a conflicting software write in the same cycle for each request bit. A design that let software win there would leave a start request armed after the start went out, or would lose a timeout-driven stop. It writes the second register with each request bit pending in turn. A lock that covered only one of the bits would let the divider change, and a lock with the wrong polarity would refuse writes while the block is idle. It pulses end-of-communication with enable set and with enable clear, and also together with a timeout. This catches a clear that ignores enable or that overrides the timeout, and an all-ones write catches reserved bits that were stored by mistake.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DIV_W    = 6;
  localparam int unsigned NUM_REQ  = 3;

  // address map
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_AUX = 2'd1;

  // control register field positions
  localparam int unsigned B_EN       = 0;
  localparam int unsigned B_SMB      = 1;
  localparam int unsigned B_HOST     = 3;
  localparam int unsigned B_ARP      = 4;
  localparam int unsigned B_CRC_EN   = 5;
  localparam int unsigned B_GC_OFF   = 6;
  localparam int unsigned B_STR_OFF  = 7;
  localparam int unsigned B_REQ_BASE = 8;   // start, stop, crc follow in order

  // request index inside the request vector
  localparam int unsigned REQ_START = 0;
  localparam int unsigned REQ_STOP  = 1;
  localparam int unsigned REQ_CRC   = 2;

  // aux register field positions
  localparam int unsigned B_DMA_EN   = 11;
  localparam int unsigned B_DMA_LAST = 12;

  localparam logic [DATA_W-1:0] CTL_CFG_MASK =
      DATA_W'((1 << B_EN) | (1 << B_SMB) | (1 << B_HOST) | (1 << B_ARP) |
              (1 << B_CRC_EN) | (1 << B_GC_OFF) | (1 << B_STR_OFF));
  localparam logic [DATA_W-1:0] CTL_REQ_MASK =
      DATA_W'(((1 << NUM_REQ) - 1) << B_REQ_BASE);
  localparam logic [DATA_W-1:0] CTL_RD_MASK = CTL_CFG_MASK | CTL_REQ_MASK;
  localparam logic [DATA_W-1:0] AUX_MASK =
      DATA_W'(((1 << DIV_W) - 1) | (1 << B_DMA_EN) | (1 << B_DMA_LAST));
endpackage

// File: rtl/i2c_ctl_rst_sync.sv
module i2c_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_ctl_bus_decode.sv
module i2c_ctl_bus_decode
  import i2c_ctl_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_i,
  output logic              ctl_we_o,
  output logic              aux_we_o
);
  always_comb begin
    ctl_we_o = wr_i && (addr_i == ADDR_CTL);
    aux_we_o = wr_i && (addr_i == ADDR_AUX) && !lock_i;
  end
endmodule

// File: rtl/i2c_ctl_masked_reg.sv
module i2c_ctl_masked_reg #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = d_i & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (we_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q & MASK;
endmodule

// File: rtl/i2c_ctl_req_bit.sv
module i2c_ctl_req_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_we_i,
  input  logic sw_d_i,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic upd;

  // hardware set outranks hardware clear, which outranks software
  always_comb begin
    q_d = q_q;
    if (hw_set_i) begin
      q_d = 1'b1;
    end else if (hw_clr_i) begin
      q_d = 1'b0;
    end else if (sw_we_i) begin
      q_d = sw_d_i;
    end
    upd = hw_set_i | hw_clr_i | sw_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/i2c_ctl_rd_mux.sv
module i2c_ctl_rd_mux
  import i2c_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  cfg_i,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [DATA_W-1:0]  aux_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] ctl_val;

  always_comb begin
    ctl_val = cfg_i & CTL_CFG_MASK;
    for (int i = 0; i < int'(NUM_REQ); i++) begin
      ctl_val[B_REQ_BASE + i] = req_i[i];
    end
    unique case (addr_i)
      ADDR_CTL: rdata_o = ctl_val;
      ADDR_AUX: rdata_o = aux_i & AUX_MASK;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ev_start_sent_i,
  input  logic              ev_stop_det_i,
  input  logic              ev_timeout_i,
  input  logic              ev_crc_sent_i,
  input  logic              ev_xfer_end_i,
  input  logic              eng_master_i,
  output logic              start_req_o,
  output logic              stop_req_o,
  output logic              crc_req_o,
  output logic              release_lines_o,
  output logic              enable_o,
  output logic              smbus_sel_o,
  output logic              smb_host_o,
  output logic              arp_en_o,
  output logic              crc_en_o,
  output logic              gcall_en_o,
  output logic              stretch_en_o,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic              dma_en_o,
  output logic              dma_last_o
);
  logic               rst_n_sync;
  logic               ctl_we;
  logic               aux_we;
  logic               lock;
  logic               abort;
  logic [DATA_W-1:0]  cfg_q;
  logic [DATA_W-1:0]  aux_q;
  logic [NUM_REQ-1:0] req_q;
  logic [NUM_REQ-1:0] req_set;
  logic [NUM_REQ-1:0] req_done;

  i2c_ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign lock  = |req_q;
  assign abort = ev_xfer_end_i & ~cfg_q[B_EN];

  i2c_ctl_bus_decode u_dec (
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .lock_i   (lock),
    .ctl_we_o (ctl_we),
    .aux_we_o (aux_we)
  );

  i2c_ctl_masked_reg #(.W(DATA_W), .MASK(CTL_CFG_MASK)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .we_i   (ctl_we),
    .d_i    (bus_wdata_i),
    .q_o    (cfg_q)
  );

  i2c_ctl_masked_reg #(.W(DATA_W), .MASK(AUX_MASK)) u_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .we_i   (aux_we),
    .d_i    (bus_wdata_i),
    .q_o    (aux_q)
  );

  // hardware event routing per request
  always_comb begin
    req_set            = '0;
    req_set[REQ_STOP]  = ev_timeout_i;
    req_done           = '0;
    req_done[REQ_START] = ev_start_sent_i;
    req_done[REQ_STOP]  = ev_stop_det_i;
    req_done[REQ_CRC]   = ev_crc_sent_i;
  end

  for (genvar g = 0; g < int'(NUM_REQ); g++) begin : g_req
    i2c_ctl_req_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_sync),
      .sw_we_i  (ctl_we),
      .sw_d_i   (bus_wdata_i[B_REQ_BASE + g]),
      .hw_set_i (req_set[g]),
      .hw_clr_i (req_done[g] | abort),
      .q_o      (req_q[g])
    );
  end

  i2c_ctl_rd_mux u_rd (
    .addr_i  (bus_addr_i),
    .cfg_i   (cfg_q),
    .req_i   (req_q),
    .aux_i   (aux_q),
    .rdata_o (bus_rdata_o)
  );

  assign start_req_o     = req_q[REQ_START];
  assign stop_req_o      = req_q[REQ_STOP];
  assign crc_req_o       = req_q[REQ_CRC];
  assign release_lines_o = req_q[REQ_STOP] & ~eng_master_i;
  assign enable_o        = cfg_q[B_EN];
  assign smbus_sel_o     = cfg_q[B_SMB];
  assign smb_host_o      = cfg_q[B_HOST];
  assign arp_en_o        = cfg_q[B_ARP];
  assign crc_en_o        = cfg_q[B_CRC_EN];
  assign gcall_en_o      = ~cfg_q[B_GC_OFF];
  assign stretch_en_o    = ~cfg_q[B_STR_OFF] & ~eng_master_i;
  assign clk_div_o       = aux_q[DIV_W-1:0];
  assign dma_en_o        = aux_q[B_DMA_EN];
  assign dma_last_o      = aux_q[B_DMA_LAST];
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
module i2c_ctl_regs_chk
  import i2c_ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n_sync,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              ev_start_sent_i,
  input logic              ev_stop_det_i,
  input logic              ev_timeout_i,
  input logic              ev_crc_sent_i,
  input logic              ev_xfer_end_i,
  input logic              start_req_o,
  input logic              stop_req_o,
  input logic              crc_req_o,
  input logic              enable_o,
  input logic [DIV_W-1:0]  clk_div_o,
  input logic              dma_en_o,
  input logic              dma_last_o
);
  a_r2_ctl_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (bus_addr_i == ADDR_CTL) |-> ((bus_rdata_o & ~CTL_RD_MASK) == '0));

  a_r3_start_sent_clears: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    ev_start_sent_i |=> !start_req_o);

  a_r4_timeout_sets_stop: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    ev_timeout_i |=> stop_req_o);

  a_r4_stop_det_clears: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (ev_stop_det_i && !ev_timeout_i) |=> !stop_req_o);

  a_r5_crc_sent_clears: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    ev_crc_sent_i |=> !crc_req_o);

  a_r6_aux_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (bus_addr_i == ADDR_AUX) |-> ((bus_rdata_o & ~AUX_MASK) == '0));

  a_r7_aux_locked: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (bus_wr_i && (bus_addr_i == ADDR_AUX) && (start_req_o || stop_req_o || crc_req_o))
    |=> ($stable(clk_div_o) && $stable(dma_en_o) && $stable(dma_last_o)));

  a_r8_xfer_end_clears: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (ev_xfer_end_i && !enable_o && !ev_timeout_i) |=> !(start_req_o || stop_req_o || crc_req_o));

  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (bus_addr_i > ADDR_AUX) |-> (bus_rdata_o == '0));
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk u_chk (
  .clk_i           (clk_i),
  .rst_n_sync      (rst_n_sync),
  .bus_wr_i        (bus_wr_i),
  .bus_addr_i      (bus_addr_i),
  .bus_rdata_o     (bus_rdata_o),
  .ev_start_sent_i (ev_start_sent_i),
  .ev_stop_det_i   (ev_stop_det_i),
  .ev_timeout_i    (ev_timeout_i),
  .ev_crc_sent_i   (ev_crc_sent_i),
  .ev_xfer_end_i   (ev_xfer_end_i),
  .start_req_o     (start_req_o),
  .stop_req_o      (stop_req_o),
  .crc_req_o       (crc_req_o),
  .enable_o        (enable_o),
  .clk_div_o       (clk_div_o),
  .dma_en_o        (dma_en_o),
  .dma_last_o      (dma_last_o)
);

// File: tb/i2c_ctl_regs_test.sv
`timescale 1ns/1ps
module i2c_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        e_start = 1'b0, e_stop = 1'b0, e_tmo = 1'b0, e_crc = 1'b0, e_end = 1'b0;
  logic        master = 1'b0;
  logic        start_req, stop_req, crc_req, release_l;
  logic        en, smb, host, arp, crc_en, gcall, stretch;
  logic [5:0]  div;
  logic        dma_en, dma_last;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  i2c_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ev_start_sent_i(e_start), .ev_stop_det_i(e_stop), .ev_timeout_i(e_tmo),
    .ev_crc_sent_i(e_crc), .ev_xfer_end_i(e_end), .eng_master_i(master),
    .start_req_o(start_req), .stop_req_o(stop_req), .crc_req_o(crc_req),
    .release_lines_o(release_l), .enable_o(en), .smbus_sel_o(smb),
    .smb_host_o(host), .arp_en_o(arp), .crc_en_o(crc_en), .gcall_en_o(gcall),
    .stretch_en_o(stretch), .clk_div_o(div), .dma_en_o(dma_en), .dma_last_o(dma_last)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // drive at negedge; state is visible at the following negedge
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(2'd0, v); check("R1 ctl reset", v, 16'h0000);
    rd_reg(2'd1, v); check("R1 aux reset", v, 16'h0000);
    check("R1 outputs low", {start_req, stop_req, crc_req, release_l, en, dma_en, dma_last, 2'b0, div},
          16'h0000);
    check("R1 gcall/stretch", {14'h0, gcall, stretch}, 16'h0003);
  endtask

  task automatic t_ctl_fields();
    logic [15:0] v;
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, v); check("R2 all ones", v, 16'h07FB);
    check("R2 field outputs", {10'h0, en, smb, host, arp, crc_en, gcall}, 16'h003E);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, v); check("R2 write zero", v, 16'h0000);
  endtask

  task automatic t_start();
    wr_reg(2'd0, 16'h0101);
    check("R3 start set", {15'h0, start_req}, 16'h1);
    e_start = 1'b1; idle(); e_start = 1'b0;
    check("R3 start cleared by event", {15'h0, start_req}, 16'h0);
    e_start = 1'b1; wr_reg(2'd0, 16'h0101); e_start = 1'b0;
    check("R3 event beats sw set", {15'h0, start_req}, 16'h0);
  endtask

  task automatic t_stop();
    master = 1'b0;
    wr_reg(2'd0, 16'h0201);
    check("R4 stop set", {15'h0, stop_req}, 16'h1);
    check("R9 slave release", {15'h0, release_l}, 16'h1);
    master = 1'b1; #1;
    check("R9 master no release", {15'h0, release_l}, 16'h0);
    master = 1'b0;
    e_stop = 1'b1; idle(); e_stop = 1'b0;
    check("R4 stop det clears", {15'h0, stop_req}, 16'h0);
    check("R9 release drops", {15'h0, release_l}, 16'h0);
    e_tmo = 1'b1; idle(); e_tmo = 1'b0;
    check("R4 timeout sets", {15'h0, stop_req}, 16'h1);
    e_tmo = 1'b1; wr_reg(2'd0, 16'h0001); e_tmo = 1'b0;
    check("R4 timeout beats sw clear", {15'h0, stop_req}, 16'h1);
    e_tmo = 1'b1; e_stop = 1'b1; idle(); e_tmo = 1'b0; e_stop = 1'b0;
    check("R4 timeout beats stop det", {15'h0, stop_req}, 16'h1);
    e_stop = 1'b1; idle(); e_stop = 1'b0;
    check("R4 stop det clears again", {15'h0, stop_req}, 16'h0);
  endtask

  task automatic t_crc();
    wr_reg(2'd0, 16'h0401);
    check("R5 crc set", {15'h0, crc_req}, 16'h1);
    e_crc = 1'b1; idle(); e_crc = 1'b0;
    check("R5 crc cleared", {15'h0, crc_req}, 16'h0);
    e_crc = 1'b1; wr_reg(2'd0, 16'h0401); e_crc = 1'b0;
    check("R5 event beats sw set", {15'h0, crc_req}, 16'h0);
  endtask

  task automatic t_aux_lock();
    logic [15:0] v;
    wr_reg(2'd0, 16'h0001);
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, v); check("R6 aux all ones", v, 16'h183F);
    check("R6 aux outputs", {8'h0, dma_last, dma_en, div}, 16'h00FF);
    for (int k = 0; k < 3; k++) begin
      wr_reg(2'd0, 16'h0001 | (16'h0100 << k));
      wr_reg(2'd1, 16'h0005);
      rd_reg(2'd1, v); check($sformatf("R7 locked by request %0d", k), v, 16'h183F);
      wr_reg(2'd0, 16'h0001);
    end
    wr_reg(2'd1, 16'h0805);
    rd_reg(2'd1, v); check("R7 unlocked write", v, 16'h0805);
  endtask

  task automatic t_xfer_end();
    logic [15:0] v;
    wr_reg(2'd0, 16'h0701);
    e_end = 1'b1; idle(); e_end = 1'b0;
    rd_reg(2'd0, v); check("R8 enabled keeps requests", v, 16'h0701);
    wr_reg(2'd0, 16'h0700);
    e_end = 1'b1; idle(); e_end = 1'b0;
    rd_reg(2'd0, v); check("R8 disabled clears requests", v, 16'h0000);
    wr_reg(2'd0, 16'h0700);
    e_end = 1'b1; e_tmo = 1'b1; idle(); e_end = 1'b0; e_tmo = 1'b0;
    rd_reg(2'd0, v); check("R8 timeout survives clear", v, 16'h0200);
    e_stop = 1'b1; idle(); e_stop = 1'b0;
  endtask

  task automatic t_stretch_gcall();
    master = 1'b0;
    wr_reg(2'd0, 16'h0080);
    check("R10 stretch disabled", {15'h0, stretch}, 16'h0);
    wr_reg(2'd0, 16'h0040);
    check("R10 stretch slave", {15'h0, stretch}, 16'h1);
    check("R10 gcall off", {15'h0, gcall}, 16'h0);
    master = 1'b1; #1;
    check("R10 stretch master", {15'h0, stretch}, 16'h0);
    master = 1'b0;
    wr_reg(2'd0, 16'h0000);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr_reg(2'd2, 16'hFFFF);
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd2, v); check("R11 addr 2 reads zero", v, 16'h0000);
    rd_reg(2'd3, v); check("R11 addr 3 reads zero", v, 16'h0000);
    rd_reg(2'd0, v); check("R11 ctl untouched", v, 16'h0000);
    rd_reg(2'd1, v); check("R11 aux untouched", v, 16'h0805);
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_start();
    t_stop();
    t_crc();
    t_aux_lock();
    t_xfer_end();
    t_stretch_gcall();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule